// File: doc/BRIEF.md
# Dual Countdown Timer

This block holds two down-counters that run from a slow tick enable of 8192 Hz, which is given as a one-cycle strobe in the fast clock domain. The short timer is four bits wide and steps down once every 256 ticks, through an 8-bit prescaler. The long timer is 32 bits wide and steps down on every tick. Both counters wrap from zero to all ones and keep running.

Software reaches both timers through a nibble-wide register port inside a 64-entry I/O window. The short timer sits at offset 0x37. The long timer is spread over offsets 0x38 to 0x3F, one nibble per offset, so it can be loaded and read four bits at a time. Each timer also drives a one-cycle flag when a decrement brings it to zero. Interrupt and wake-up logic elsewhere in the chip can use these flags.

Top module: `dual_cdtimer`

## Requirements
- R1: After a synchronous reset, both timers, the prescaler, `rd_data`, `t1_zero` and `t2_zero` are all zero.
- R2: On every cycle with `tick` high, the long timer drops by one, and it wraps from 0x00000000 to 0xFFFFFFFF. Without a tick, it keeps its value.
- R3: The short timer drops by one on every 256th tick, the first time on the 256th tick after reset, and it wraps from 0x0 to 0xF. Ticks count whether or not a write happens.
- R4: A write to offset 0x37 loads `wr_data` into the short timer.
- R5: A write to offset 0x38+i, for i from 0 to 7, replaces nibble i of the long timer, where nibble 0 is bits 3:0. The other seven nibbles keep their values.
- R6: If a write to a timer falls in a cycle where that timer would decrement, the written value wins and the timer does not step down in that cycle. The prescaler still advances.
- R7: A read (`rd_en`) returns the addressed nibble on `rd_data` one cycle later, as the value was before that clock edge. While `rd_en` is low, `rd_data` holds its value.
- R8: A read of any offset outside 0x37 to 0x3F returns 0. A write to such an offset changes neither timer.
- R9: `t1_zero` is high for exactly the one cycle in which a decrement has just brought the short timer to 0. Loading 0 with a write does not raise it.
- R10: `t2_zero` is high for exactly the one cycle in which a decrement has just brought the long timer to 0. Loading 0 with a write does not raise it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe at 8192 Hz |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 6 | Register offset within the I/O window |
| wr_data | input | 4 | Write nibble |
| rd_data | output | 4 | Registered read nibble |
| t1_zero | output | 1 | Short timer reached zero (one cycle) |
| t2_zero | output | 1 | Long timer reached zero (one cycle) |

## Verification
Two pairs of events can land on the same edge.

- **Software write and decrement.** A load of a long-timer nibble can come together with a tick, and a load of the short timer can come together with the prescaler wrapping. The bench tracks the prescaler count in its own model, so it can place a short-timer write exactly on the 256th tick. The write must then win, no step down may follow, and no zero flag may appear.
- **Read and write.** A read of an offset can come in the same cycle as a write to that offset. The read must return the old nibble, and a later read must show the new one.

// File: rtl/dct_pkg.sv
package dct_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_T1   = 2'd1,
    SEL_T2   = 2'd2
  } dct_sel_t;
endpackage

// File: rtl/dct_decode.sv
module dct_decode
  import dct_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int T1_ADDR = 'h37,
  parameter int T2_BASE = 'h38,
  parameter int T2_NIBS = 8,
  parameter int IDX_W   = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output dct_sel_t          sel,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    sel = SEL_NONE;
    idx = IDX_W'(addr - ADDR_W'(T2_BASE));
    if (int'(addr) == T1_ADDR)
      sel = SEL_T1;
    else if (int'(addr) >= T2_BASE && int'(addr) < T2_BASE + T2_NIBS)
      sel = SEL_T2;
  end
endmodule

// File: rtl/dct_prescaler.sv
module dct_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic wrap
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end

  // The strobe for the slow timer fires on the tick that rolls the count over.
  assign wrap = tick && (&cnt_q);
endmodule

// File: rtl/dct_nib_counter.sv
module dct_nib_counter #(
  parameter int NIB_W = 4,
  parameter int NIBS  = 8,
  parameter int IDX_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  dec_en,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [NIB_W-1:0]      wr_data,
  output logic [NIB_W*NIBS-1:0] q,
  output logic                  zero_pulse
);
  localparam int CW = NIB_W * NIBS;

  logic [NIB_W-1:0] nib_q [NIBS];
  logic [CW-1:0]    dec_val;

  assign dec_val = q - CW'(1);

  for (genvar i = 0; i < NIBS; i++) begin : g_nib
    always_ff @(posedge clk) begin
      if (rst)
        nib_q[i] <= '0;
      else if (wr_en) begin
        if (wr_idx == IDX_W'(i)) nib_q[i] <= wr_data;
      end else if (dec_en)
        nib_q[i] <= dec_val[i*NIB_W +: NIB_W];
    end
    assign q[i*NIB_W +: NIB_W] = nib_q[i];
  end

  // A write blocks the decrement, so only a real decrement from one reports zero.
  always_ff @(posedge clk) begin
    if (rst) zero_pulse <= 1'b0;
    else     zero_pulse <= dec_en && !wr_en && (q == CW'(1));
  end
endmodule

// File: rtl/dual_cdtimer.sv
module dual_cdtimer
  import dct_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int NIB_W   = 4,
  parameter int T2_NIBS = 8,
  parameter int PRE_W   = 8,
  parameter int T1_ADDR = 'h37,
  parameter int T2_BASE = 'h38
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NIB_W-1:0]  wr_data,
  output logic [NIB_W-1:0]  rd_data,
  output logic              t1_zero,
  output logic              t2_zero
);
  localparam int IDX_W = (T2_NIBS > 1) ? $clog2(T2_NIBS) : 1;
  localparam int T2_W  = NIB_W * T2_NIBS;

  dct_sel_t          sel;
  logic [IDX_W-1:0]  idx;
  logic              wr_t1, wr_t2, pre_wrap;
  logic [NIB_W-1:0]  t1_q;
  logic [T2_W-1:0]   t2_q;

  dct_decode #(
    .ADDR_W(ADDR_W), .T1_ADDR(T1_ADDR), .T2_BASE(T2_BASE),
    .T2_NIBS(T2_NIBS), .IDX_W(IDX_W)
  ) u_dec (
    .addr(addr), .sel(sel), .idx(idx)
  );

  assign wr_t1 = wr_en && (sel == SEL_T1);
  assign wr_t2 = wr_en && (sel == SEL_T2);

  dct_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .tick(tick), .wrap(pre_wrap)
  );

  dct_nib_counter #(.NIB_W(NIB_W), .NIBS(1), .IDX_W(1)) u_t1 (
    .clk(clk), .rst(rst), .dec_en(pre_wrap), .wr_en(wr_t1),
    .wr_idx(1'b0), .wr_data(wr_data), .q(t1_q), .zero_pulse(t1_zero)
  );

  dct_nib_counter #(.NIB_W(NIB_W), .NIBS(T2_NIBS), .IDX_W(IDX_W)) u_t2 (
    .clk(clk), .rst(rst), .dec_en(tick), .wr_en(wr_t2),
    .wr_idx(idx), .wr_data(wr_data), .q(t2_q), .zero_pulse(t2_zero)
  );

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (rd_en) begin
      unique case (sel)
        SEL_T1:  rd_data <= t1_q;
        SEL_T2:  rd_data <= t2_q[idx*NIB_W +: NIB_W];
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/dual_cdtimer_chk.sv
module dual_cdtimer_chk #(
  parameter int ADDR_W  = 6,
  parameter int NIB_W   = 4,
  parameter int T2_NIBS = 8,
  parameter int T1_ADDR = 'h37,
  parameter int T2_BASE = 'h38
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     tick,
  input logic                     wr_en,
  input logic                     rd_en,
  input logic [ADDR_W-1:0]        addr,
  input logic [NIB_W-1:0]         wr_data,
  input logic [NIB_W-1:0]         rd_data,
  input logic                     t1_zero,
  input logic                     t2_zero,
  input logic [NIB_W-1:0]         t1_val,
  input logic [NIB_W*T2_NIBS-1:0] t2_val
);
  localparam int T2_W = NIB_W * T2_NIBS;

  logic at_t1, at_t2;
  assign at_t1 = (int'(addr) == T1_ADDR);
  assign at_t2 = (int'(addr) >= T2_BASE) && (int'(addr) < T2_BASE + T2_NIBS);

  // R2
  t2_step_chk: assert property (@(posedge clk) disable iff (rst)
    tick && !(wr_en && at_t2) |=> t2_val == $past(t2_val) - T2_W'(1));
  // R2
  t2_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tick && !(wr_en && at_t2) |=> $stable(t2_val));
  // R3
  t1_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !tick && !(wr_en && at_t1) |=> $stable(t1_val));
  // R4
  t1_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en && at_t1 |=> t1_val == $past(wr_data));
  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
  // R8
  rd_unmapped_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en && !at_t1 && !at_t2 |=> rd_data == '0);
  // R9
  t1_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    t1_zero |-> t1_val == '0 && $past(t1_val) == NIB_W'(1));
  // R9
  t1_single_chk: assert property (@(posedge clk) disable iff (rst)
    t1_zero |=> !t1_zero);
  // R10
  t2_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    t2_zero |-> t2_val == '0 && $past(t2_val) == T2_W'(1));
  // R10
  t2_single_chk: assert property (@(posedge clk) disable iff (rst)
    t2_zero |=> !t2_zero);
endmodule

bind dual_cdtimer dual_cdtimer_chk #(
  .ADDR_W(ADDR_W), .NIB_W(NIB_W), .T2_NIBS(T2_NIBS),
  .T1_ADDR(T1_ADDR), .T2_BASE(T2_BASE)
) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
  .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
  .t1_zero(t1_zero), .t2_zero(t2_zero), .t1_val(t1_q), .t2_val(t2_q)
);

// File: tb/dual_cdtimer_bench.sv
module dual_cdtimer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [5:0] addr = '0;
  logic [3:0] wr_data = '0;
  logic [3:0] rd_data;
  logic       t1_zero, t2_zero;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_cdtimer u_dual_cdtimer (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
    .t1_zero(t1_zero), .t2_zero(t2_zero)
  );

  typedef struct {
    logic [3:0] rd;
    logic       z1;
    logic       z2;
    string      tag;
  } exp_t;

  exp_t sb[$];

  // Reference model of the requirements
  logic [7:0]  m_pre = '0;
  logic [3:0]  m_t1 = '0;
  logic [31:0] m_t2 = '0;
  logic [3:0]  m_rd = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic tk, input logic we, input logic re,
                      input logic [5:0] a, input logic [3:0] d, input string tag);
    exp_t it;
    logic wrap, hit1, hit2;
    int   n;
    @(negedge clk);
    tick = tk; wr_en = we; rd_en = re; addr = a; wr_data = d;
    wrap = tk && (m_pre == 8'hFF);
    hit1 = we && (a == 6'h37);
    hit2 = we && (a >= 6'h38);
    n    = int'(a) - 'h38;
    it.z1 = !hit1 && wrap && (m_t1 == 4'h1);
    it.z2 = !hit2 && tk && (m_t2 == 32'h1);
    if (re) begin
      if (a == 6'h37)      m_rd = m_t1;
      else if (a >= 6'h38) m_rd = 4'(m_t2 >> (4 * n));
      else                 m_rd = 4'h0;
    end
    it.rd  = m_rd;
    it.tag = tag;
    if (tk) m_pre = m_pre + 8'h1;
    if (hit1)      m_t1 = d;
    else if (wrap) m_t1 = m_t1 - 4'h1;
    if (hit2) begin
      m_t2 = m_t2 & ~(32'hF << (4 * n));
      m_t2 = m_t2 | (32'(d) << (4 * n));
    end else if (tk)
      m_t2 = m_t2 - 32'h1;
    sb.push_back(it);
  endtask

  // Monitor: compares outputs a quarter period after each edge
  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      chk(rd_data == it.rd, it.tag, "rd_data", 32'(rd_data), 32'(it.rd));
      chk(t1_zero == it.z1, it.tag, "t1_zero", 32'(t1_zero), 32'(it.z1));
      chk(t2_zero == it.z2, it.tag, "t2_zero", 32'(t2_zero), 32'(it.z2));
    end
  end

  task automatic read_t2(input string tag);
    for (int i = 0; i < 8; i++) step(0, 0, 1, 6'(8'h38 + i), 4'h0, tag);
  endtask

  task automatic load_t2(input logic [31:0] v, input string tag);
    for (int i = 0; i < 8; i++) step(0, 1, 0, 6'(8'h38 + i), 4'(v >> (4 * i)), tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(rd_data == 4'h0, "R1", "rd_data", 32'(rd_data), 0);
    chk(t1_zero == 1'b0, "R1", "t1_zero", 32'(t1_zero), 0);
    chk(t2_zero == 1'b0, "R1", "t2_zero", 32'(t2_zero), 0);
    rst = 1'b0;
    step(0, 0, 1, 6'h37, 4'h0, "R1");
    read_t2("R1");
    // R8: unmapped reads
    step(0, 0, 1, 6'h00, 4'h0, "R8");
    step(0, 0, 1, 6'h36, 4'h0, "R8");
    // R2: wrap from zero on a tick
    step(1, 0, 0, 6'h00, 4'h0, "R2");
    read_t2("R2");
    // R5: nibble load and partial replace
    load_t2(32'h0000_0003, "R5");
    step(0, 1, 0, 6'h3D, 4'hA, "R5");
    read_t2("R5");
    step(0, 1, 0, 6'h3D, 4'h0, "R5");
    // R10 / R2: countdown through zero with reads of nibble 0
    for (int i = 0; i < 5; i++) step(1, 0, 1, 6'h38, 4'h0, "R10");
    read_t2("R2");
    // R6: write to nibble coincides with a tick
    step(1, 1, 0, 6'h38, 4'h5, "R6");
    read_t2("R6");
    // R10: loading zero raises no flag
    load_t2(32'h0, "R10");
    step(0, 0, 0, 6'h00, 4'h0, "R10");
    // R8: writes to unmapped offsets touch nothing
    step(0, 1, 0, 6'h36, 4'hF, "R8");
    step(0, 1, 0, 6'h10, 4'hF, "R8");
    step(0, 0, 1, 6'h37, 4'h0, "R8");
    read_t2("R8");
    // R4: load short timer
    step(0, 1, 0, 6'h37, 4'h2, "R4");
    step(0, 0, 1, 6'h37, 4'h0, "R4");
    // R3: run until the prescaler is one tick from wrapping
    while (m_pre != 8'hFF) step(1, 0, 1, 6'h37, 4'h0, "R3");
    // R6: load lands on the prescaler wrap
    step(1, 1, 0, 6'h37, 4'h1, "R6");
    step(0, 0, 1, 6'h37, 4'h0, "R6");
    // R9 then R3: decrement 1 to 0, then 0 to F
    for (int i = 0; i < 520; i++) step(1, 0, 1, 6'h37, 4'h0, "R9");
    step(0, 0, 1, 6'h37, 4'h0, "R3");
    // R7: hold without read, then read in the cycle of a write
    for (int i = 0; i < 3; i++) step(0, 0, 0, 6'h37, 4'h0, "R7");
    step(0, 1, 1, 6'h37, 4'h7, "R7");
    step(0, 0, 1, 6'h37, 4'h0, "R7");
    step(0, 0, 0, 6'h00, 4'h0, "R7");
    wait (sb.size() == 0);
    #10;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule